// File: doc/BRIEF.md
# Branch Condition and Target Unit

This combinational unit looks at one 16-bit instruction word together with the address it was fetched from and the four condition flags (negative, zero, overflow, carry). It reports whether the word is a PC-relative branch, whether that branch is taken under the current flags, and the address the branch goes to. The fetch logic of a small 16-bit processor uses these three outputs to choose the next program counter.

Branches live where the top three bits of the word are zero. Bits 12:10 choose one of eight condition groups. Bits 9:1 carry a signed word offset. Bit 0 inverts the sense of the test, so each pair of opposite branches (equal / not equal, and so on) shares one group. Group zero with bit 0 clear is the space used by the system instructions (halt, interrupt return, status moves). The unit recognises that space only to keep those instructions away from the branch outputs.

Top module: `brc_unit`

## Requirements
- R1: `is_branch` is 1 exactly when bits 15:13 of `instr_word` are 000 and the word is not a system word as defined in R2.
- R2: A word with bits 15:10 equal to 000000 and bit 0 equal to 0 is a system word: `is_branch` and `br_taken` are both 0 for any flag values.
- R3: A word with bits 15:10 equal to 000000 and bit 0 equal to 1 is an unconditional branch: `br_taken` is 1 for every flag combination.
- R4: Groups (bits 12:10) 001, 100, 110 and 111 test Z, C, N and V respectively.
- R5: Group 010 tests N xor V (signed less-than), and group 011 tests (N xor V) or Z (signed less-or-equal).
- R6: Group 101 tests C or Z (unsigned lower-or-same).
- R7: For groups 001 to 111, a branch with bit 0 = 0 is taken when its test is 1, and a branch with bit 0 = 1 is taken when its test is 0.
- R8: `br_target` equals `instr_addr` + 2 + 2 × offset modulo 2^16, where the offset is bits 9:1 read as a 9-bit two's complement value (−256 to +255).
- R9: Bit 0 of `br_target` is always 0; bit 0 of `instr_addr` has no effect on the target.
- R10: When bits 15:13 are not 000, `is_branch` and `br_taken` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 16 | Instruction word under decode |
| instr_addr | input | 16 | Byte address of that instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| is_branch | output | 1 | Word is a PC-relative branch |
| br_taken | output | 1 | Branch is taken under the current flags |
| br_target | output | 16 | Branch destination address |

## Verification
The hardest cases to reach are the edges of the offset range combined with an instruction address near either end of the 16-bit space, where the target has to wrap. Plain random words seldom hit them. Directed vectors set the offset field to its most negative, its most positive, minus one and zero, and pair each with an address close to 0x0000 or 0xFFFE. The condition logic is driven exhaustively: every group, both senses and all sixteen flag combinations are applied.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [2:0] {
    GRP_ALWAYS = 3'd0,
    GRP_EQ     = 3'd1,
    GRP_SLT    = 3'd2,
    GRP_SLE    = 3'd3,
    GRP_ULT    = 3'd4,
    GRP_ULE    = 3'd5,
    GRP_NEG    = 3'd6,
    GRP_OVF    = 3'd7
  } cond_grp_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  // Raw test value of a condition group, before the sense bit is applied.
  function automatic logic cond_test(input cond_grp_e grp, input flags_t f);
    logic signed_lt;
    signed_lt = f.n ^ f.v;
    unique case (grp)
      GRP_ALWAYS: cond_test = 1'b0;
      GRP_EQ:     cond_test = f.z;
      GRP_SLT:    cond_test = signed_lt;
      GRP_SLE:    cond_test = signed_lt | f.z;
      GRP_ULT:    cond_test = f.c;
      GRP_ULE:    cond_test = f.c | f.z;
      GRP_NEG:    cond_test = f.n;
      GRP_OVF:    cond_test = f.v;
      default:    cond_test = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/brc_decode.sv
module brc_decode #(
  parameter int INSTR_W = 16,
  parameter int OFFS_W  = 9,
  parameter int GRP_W   = 3
) (
  input  logic [INSTR_W-1:0] instr_word,
  output logic               is_sys,
  output logic               is_branch,
  output logic               is_uncond,
  output logic [GRP_W-1:0]   grp,
  output logic               sense_inv,
  output logic [OFFS_W-1:0]  offset
);
  localparam int OFFS_LSB = 1;
  localparam int GRP_LSB  = OFFS_LSB + OFFS_W;
  localparam int MAJ_LSB  = GRP_LSB + GRP_W;
  localparam int MAJ_W    = INSTR_W - MAJ_LSB;

  logic major_zero;
  logic grp_zero;

  always_comb begin
    major_zero = (instr_word[INSTR_W-1:MAJ_LSB] == {MAJ_W{1'b0}});
    grp        = instr_word[MAJ_LSB-1:GRP_LSB];
    grp_zero   = (grp == {GRP_W{1'b0}});
    offset     = instr_word[GRP_LSB-1:OFFS_LSB];
    sense_inv  = instr_word[0];
    is_sys     = major_zero & grp_zero & ~sense_inv;
    is_uncond  = major_zero & grp_zero &  sense_inv;
    is_branch  = major_zero & ~is_sys;
  end
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
#(
  parameter int GRP_W = 3
) (
  input  logic [GRP_W-1:0] grp,
  input  flags_t           flags,
  output logic             cond_raw
);
  always_comb begin
    cond_raw = cond_test(cond_grp_e'(grp), flags);
  end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 9
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFFS_W-1:0] offset,
  output logic [ADDR_W-1:0] target
);
  localparam int                EXT_W     = ADDR_W - OFFS_W - 1;
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] EVEN_MASK = ~ADDR_W'(1);

  // Sign-extend the word offset and turn it into a byte displacement.
  function automatic logic [ADDR_W-1:0] byte_disp(input logic [OFFS_W-1:0] off);
    byte_disp = {{EXT_W{off[OFFS_W-1]}}, off, 1'b0};
  endfunction

  logic [ADDR_W-1:0] raw_sum;

  always_comb begin
    raw_sum = base_addr + STEP + byte_disp(offset);
    target  = raw_sum & EVEN_MASK;
  end
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int ADDR_W  = 16,
  parameter int OFFS_W  = 9,
  parameter int GRP_W   = 3
) (
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [ADDR_W-1:0]  instr_addr,
  input  logic               flag_n,
  input  logic               flag_z,
  input  logic               flag_v,
  input  logic               flag_c,
  output logic               is_branch,
  output logic               br_taken,
  output logic [ADDR_W-1:0]  br_target
);
  logic              is_sys;
  logic              is_uncond;
  logic [GRP_W-1:0]  grp;
  logic              sense_inv;
  logic [OFFS_W-1:0] offset;
  logic              cond_raw;
  flags_t            flags;

  assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

  brc_decode #(.INSTR_W(INSTR_W), .OFFS_W(OFFS_W), .GRP_W(GRP_W)) u_dec (
    .instr_word (instr_word),
    .is_sys     (is_sys),
    .is_branch  (is_branch),
    .is_uncond  (is_uncond),
    .grp        (grp),
    .sense_inv  (sense_inv),
    .offset     (offset)
  );

  brc_cond_eval #(.GRP_W(GRP_W)) u_cond (
    .grp      (grp),
    .flags    (flags),
    .cond_raw (cond_raw)
  );

  brc_target #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_tgt (
    .base_addr (instr_addr),
    .offset    (offset),
    .target    (br_target)
  );

  always_comb begin
    if (!is_branch)     br_taken = 1'b0;
    else if (is_uncond) br_taken = 1'b1;
    else                br_taken = cond_raw ^ sense_inv;
  end
endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
  parameter int INSTR_W = 16,
  parameter int ADDR_W  = 16
) (
  input logic [INSTR_W-1:0] instr_word,
  input logic [ADDR_W-1:0]  instr_addr,
  input logic               is_branch,
  input logic               br_taken,
  input logic [ADDR_W-1:0]  br_target,
  input logic               is_sys,
  input logic               cond_raw
);
  localparam int TOP = INSTR_W - 1;

  always_comb begin
    // R10
    if (br_taken)
      p_taken_in_branch_r10: assert (is_branch) else $error("taken outside branch space");
    // R1
    if (is_branch)
      p_major_zero_r1: assert (instr_word[TOP -: 3] == 3'b000) else $error("branch with nonzero major field");
    // R2
    if (is_sys)
      p_sys_quiet_r2: assert (!is_branch && !br_taken) else $error("system word leaked to branch outputs");
    // R3
    if (instr_word[TOP -: 6] == 6'd0 && instr_word[0])
      p_always_taken_r3: assert (br_taken) else $error("unconditional branch not taken");
    // R7
    if (is_branch && instr_word[12:10] != 3'd0)
      p_sense_r7: assert (br_taken == (cond_raw ^ instr_word[0])) else $error("sense bit not honoured");
    // R9
    p_target_even_r9: assert (br_target[0] == 1'b0) else $error("odd target");
    // R8
    if (instr_word[9:1] == 9'd0)
      p_zero_offset_r8: assert (br_target == ((instr_addr + ADDR_W'(2)) & ~ADDR_W'(1)))
        else $error("zero offset target wrong");
  end
endmodule

bind brc_unit brc_unit_chk #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) u_chk (
  .instr_word (instr_word),
  .instr_addr (instr_addr),
  .is_branch  (is_branch),
  .br_taken   (br_taken),
  .br_target  (br_target),
  .is_sys     (is_sys),
  .cond_raw   (cond_raw)
);

// File: tb/tb_brc_unit.sv
module tb_brc_unit;
  logic        clk = 1'b0;
  logic [15:0] instr_word = 16'h0000;
  logic [15:0] instr_addr = 16'h0000;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
  logic        is_branch, br_taken;
  logic [15:0] br_target;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  brc_unit dut (
    .instr_word (instr_word),
    .instr_addr (instr_addr),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_v     (flag_v),
    .flag_c     (flag_c),
    .is_branch  (is_branch),
    .br_taken   (br_taken),
    .br_target  (br_target)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h (word=0x%04h addr=0x%04h nzvc=%b%b%b%b)",
               req, what, got, exp, instr_word, instr_addr, flag_n, flag_z, flag_v, flag_c);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic [15:0] a, input logic [3:0] nzvc);
    @(negedge clk);
    instr_word = w;
    instr_addr = a;
    {flag_n, flag_z, flag_v, flag_c} = nzvc;
    #1;
  endtask

  // Independent model of the condition tables.
  function automatic bit model_taken(input int grp, input bit inv, input logic [3:0] nzvc);
    bit n, z, v, c, t;
    {n, z, v, c} = nzvc;
    if (grp == 0) return inv;
    case (grp)
      1: t = z;
      2: t = (n != v);
      3: t = (n != v) || z;
      4: t = c;
      5: t = c || z;
      6: t = n;
      default: t = v;
    endcase
    return inv ? !t : t;
  endfunction

  function automatic string grp_req(input int grp);
    if (grp == 2 || grp == 3) return "R5";
    if (grp == 5) return "R6";
    return "R4";
  endfunction

  function automatic int model_target(input logic [15:0] a, input logic [8:0] off);
    int d;
    d = off[8] ? int'(off) - 512 : int'(off);
    return (int'(a) + 2 + 2 * d) & 32'hFFFE;
  endfunction

  task automatic t_idle;
    apply(16'h0000, 16'h0000, 4'h0);
    chk("R2", "idle is_branch", is_branch, 0);
    chk("R2", "idle taken", br_taken, 0);
  endtask

  task automatic t_system;
    logic [15:0] words [4] = '{16'h0000, 16'h0002, 16'h0004, 16'h0386};
    foreach (words[i]) begin
      for (int f = 0; f < 16; f++) begin
        apply(words[i], 16'h0100, 4'(f));
        chk("R2", "sys is_branch", is_branch, 0);
        chk("R2", "sys taken", br_taken, 0);
      end
    end
  endtask

  task automatic t_uncond;
    for (int f = 0; f < 16; f++) begin
      apply(16'h0001 | 16'(f << 3), 16'h2000, 4'(f));
      chk("R3", "uncond taken", br_taken, 1);
      chk("R1", "uncond is_branch", is_branch, 1);
    end
  endtask

  task automatic t_groups;
    for (int g = 1; g < 8; g++) begin
      for (int s = 0; s < 2; s++) begin
        for (int f = 0; f < 16; f++) begin
          apply(16'((g << 10) | (5 << 1) | s), 16'h0400, 4'(f));
          chk("R1", "cond is_branch", is_branch, 1);
          chk(grp_req(g), "cond taken (R7 sense)", br_taken, model_taken(g, s[0], 4'(f)));
        end
      end
    end
  endtask

  task automatic t_non_branch;
    logic [15:0] words [6] = '{16'h2000, 16'h2001, 16'h4001, 16'h8001, 16'hE7FF, 16'hFFFF};
    foreach (words[i]) begin
      for (int f = 0; f < 16; f++) begin
        apply(words[i], 16'h0800, 4'(f));
        chk("R10", "non-branch is_branch", is_branch, 0);
        chk("R10", "non-branch taken", br_taken, 0);
      end
    end
  endtask

  task automatic t_target;
    logic [15:0] addrs [6] = '{16'h1000, 16'h0002, 16'hFFFE, 16'h0000, 16'h7FFE, 16'h1001};
    logic [8:0]  offs  [6] = '{9'h000, 9'h0FF, 9'h100, 9'h1FF, 9'h001, 9'h080};
    foreach (addrs[i]) begin
      foreach (offs[j]) begin
        apply(16'((4 << 10) | (int'(offs[j]) << 1)), addrs[i], 4'h0);
        chk(addrs[i][0] ? "R9" : "R8", "target", br_target, model_target(addrs[i], offs[j]));
        chk("R9", "target bit0", br_target[0], 0);
      end
    end
    // explicit wrap corners
    apply(16'h0001, 16'hFFFE, 4'h0);
    chk("R8", "wrap up", br_target, 16'h0000);
    apply(16'h0201, 16'h0002, 4'h0);
    chk("R8", "wrap down", br_target, 16'hFE04);
    apply(16'h01FF, 16'h1000, 4'h0);
    chk("R8", "max forward", br_target, 16'h1200);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_system();
    t_uncond();
    t_groups();
    t_non_branch();
    t_target();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule